// File: doc/BRIEF.md
# MESI Snooping Cache Coherence Controller

This block holds the tag and coherence state of every line in one private, direct-mapped cache that sits on a shared snooping bus. The block uses the four-state MESI protocol: Invalid, Shared, Exclusive-clean and Modified. A processor presents loads and stores one at a time. For each one the block reports whether the line was present and which state it ends in, and a separate data array uses that report. Data storage is not part of this block.

On a miss, on an upgrade of a Shared line, or when a dirty victim is evicted, the controller requests the bus and waits for a grant. It then places a read, read-for-ownership or writeback command on the bus. At the same time it watches the commands that the other caches issue. A snooped hit on a dirty line raises a flush pulse. A snooped read that hits any valid line raises the shared output in the next cycle. That shared output feeds the requester's shared input.

Each granted transaction takes the grant cycle plus one response cycle. The arbiter must not grant during the response cycle. The order in which the bus grants transactions is the coherence order.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. In the first cycle after reset, cpu_ready is high and bus_req, resp_valid, shared_out and flush_valid are low. States are reported as I=0, S=1, E=2, M=3.
- R2: A load that hits a valid line returns resp_hit=1 and the unchanged state one cycle after acceptance, with no bus transaction.
- R3: A store that hits an Exclusive or Modified line returns resp_hit=1 and state M one cycle after acceptance, with no bus transaction.
- R4: A store that hits a Shared line issues one read-for-ownership (bus_cmd=2) and then returns resp_hit=1 and state M.
- R5: A load miss issues one read (bus_cmd=1). The block samples shared_in in the cycle after the grant and installs the line as S if it is high, or as E if it is low. It returns resp_hit=0.
- R6: A store miss issues one read-for-ownership and installs the line as M, returning resp_hit=0.
- R7: A snooped read (snoop_cmd=1) that hits an M line raises flush_valid, with flush_addr equal to the line, one cycle later and leaves the line S. If it hits an E line, the line goes to S with no flush.
- R8: A snooped read-for-ownership (snoop_cmd=2) that hits an M line flushes it and invalidates it. One that hits an S or E line invalidates it with no flush.
- R9: shared_out is high exactly in the cycle after a snooped read hits a valid line.
- R10: A miss whose set holds a different Modified line first issues a writeback (bus_cmd=3) of that line's address and then the miss request. A clean victim is dropped with no bus traffic.
- R11: A snooped transaction is applied before any local request that has not yet been granted. When two caches upgrade the same Shared line together, both report M. The cache granted first ends Invalid after a flush, and the cache granted second holds the line M.
- R12: A line is never held Modified or Exclusive in one cache while another cache holds it valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_ready | output | 1 | Controller can accept a request this cycle |
| resp_valid | output | 1 | Completion pulse |
| resp_hit | output | 1 | Line was valid when the request was accepted |
| resp_state | output | 2 | Line state after the request |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; a transaction happens when bus_req and bus_gnt are both high |
| bus_cmd | output | 2 | Command: 1 read, 2 read-for-ownership, 3 writeback |
| bus_addr | output | ADDR_W | Line address of the command |
| shared_in | input | 1 | Another cache holds the line; sampled in the response cycle |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snoop_addr | input | ADDR_W | Snooped line address |
| shared_out | output | 1 | A snooped read hit a valid line here |
| flush_valid | output | 1 | A dirty line is being supplied because of a snoop |
| flush_addr | output | ADDR_W | Address of the flushed line |

## Verification
A wrong stored state becomes visible at the ports in one of three ways, no later than the next access to the line. A load to that line reports the wrong resp_state one cycle after acceptance. A bus command appears where none should, or is missing where one should appear. A flush or shared pulse from the other cache appears or is missing in the response cycle. The bench runs two controllers on one bus and a behavioural state model of both caches. For every operation it compares the response, the number and kind of bus commands, and the other cache's flush and shared pulses. A corrupted state is therefore reported at the first operation that touches the line.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_t;

  // State of a line after another cache's command hits it
  function automatic mesi_t snoop_next(input mesi_t s, input bus_cmd_t c);
    mesi_t n;
    n = s;
    case (c)
      CMD_RD:  n = (s == ST_I) ? ST_I : ST_S;
      CMD_RDX: n = ST_I;
      default: n = s;
    endcase
    return n;
  endfunction

  // A snooped read or ownership request that hits a dirty line must be supplied
  function automatic logic snoop_dirty(input mesi_t s, input bus_cmd_t c);
    return (s == ST_M) && ((c == CMD_RD) || (c == CMD_RDX));
  endfunction

endpackage

// File: rtl/mesi_line_slot.sv
module mesi_line_slot
  import mesi_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             snp_sel,
  input  logic [TAG_W-1:0] snp_tag,
  input  bus_cmd_t         snp_cmd,
  input  logic             upd_en,
  input  logic [TAG_W-1:0] upd_tag,
  input  mesi_t            upd_state,
  output logic [TAG_W-1:0] tag_o,
  output mesi_t            state_o,
  output logic             snp_hit
);

  logic [TAG_W-1:0] tag_q;
  mesi_t            state_q;

  assign snp_hit = snp_sel && (state_q != ST_I) && (tag_q == snp_tag);
  assign tag_o   = tag_q;
  assign state_o = state_q;

  // The local update was computed from the post-snoop view, so it has priority
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_I;
      tag_q   <= '0;
    end else if (upd_en) begin
      state_q <= upd_state;
      tag_q   <= upd_tag;
    end else if (snp_hit) begin
      state_q <= snoop_next(state_q, snp_cmd);
    end
  end

  // R3: Modified is entered only through a local update
  a_r3_m_only_local: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_M && $past(state_q) != ST_M) |-> $past(upd_en));

  // R8: an ownership snoop leaves nothing valid behind
  a_r8_rdx_invalidates: assert property (@(posedge clk) disable iff (rst)
    (snp_hit && snp_cmd == CMD_RDX && !upd_en) |=> (state_q == ST_I));

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snoop_valid,
  input  bus_cmd_t          snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              hit,
  input  mesi_t             hit_state,
  output logic              shared_out,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_addr
);

  logic              shared_q;
  logic              flush_q;
  logic [ADDR_W-1:0] flush_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shared_q     <= 1'b0;
      flush_q      <= 1'b0;
      flush_addr_q <= '0;
    end else begin
      shared_q <= snoop_valid && hit && (snoop_cmd == CMD_RD);
      flush_q  <= snoop_valid && hit && snoop_dirty(hit_state, snoop_cmd);
      if (snoop_valid && hit) flush_addr_q <= snoop_addr;
    end
  end

  assign shared_out  = shared_q;
  assign flush_valid = flush_q;
  assign flush_addr  = flush_addr_q;

  // R7: dirty hit by a read is flushed in the next cycle with its address
  a_r7_flush_on_read: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && hit && hit_state == ST_M && snoop_cmd == CMD_RD)
      |=> (flush_valid && flush_addr == $past(snoop_addr)));

  // R9: a read hitting a valid line raises shared in the next cycle
  a_r9_shared_on_hit: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && hit && snoop_cmd == CMD_RD) |=> shared_out);

  // R8: ownership snoops never report sharing
  a_r8_rdx_not_shared: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && snoop_cmd == CMD_RDX) |=> !shared_out);

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SET_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  mesi_t             look_state,
  input  logic [ADDR_W-SET_W-1:0] look_tag,
  input  logic [(1<<SET_W)-1:0]   snp_hit_vec,
  input  bus_cmd_t          snp_cmd,
  input  logic              bus_gnt,
  input  logic              shared_in,
  output logic              cpu_ready,
  output logic              upd_en,
  output logic [SET_W-1:0]  upd_set,
  output logic [ADDR_W-SET_W-1:0] upd_tag,
  output mesi_t             upd_state,
  output logic              bus_req,
  output bus_cmd_t          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              resp_valid,
  output logic              resp_hit,
  output mesi_t             resp_state
);

  localparam int TAG_W = ADDR_W - SET_W;

  typedef enum logic [1:0] {F_IDLE, F_WB, F_REQ, F_RSP} fsm_t;

  fsm_t              fsm_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_write_q;
  logic              pend_hit_q;
  logic              req_q;
  bus_cmd_t          cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rv_q;
  logic              rh_q;
  mesi_t             rs_q;

  logic [SET_W-1:0] cpu_set;
  logic [TAG_W-1:0] cpu_tag;
  logic [SET_W-1:0] pend_set;
  logic [TAG_W-1:0] pend_tag;
  logic             look_hit;
  logic             quick_done;
  logic             granted;
  logic             victim_lost;
  bus_cmd_t         main_cmd;
  mesi_t            fill_state;

  assign cpu_set    = cpu_addr[SET_W-1:0];
  assign cpu_tag    = cpu_addr[ADDR_W-1:SET_W];
  assign pend_set   = pend_addr_q[SET_W-1:0];
  assign pend_tag   = pend_addr_q[ADDR_W-1:SET_W];
  assign look_hit   = (look_state != ST_I) && (look_tag == cpu_tag);
  assign quick_done = look_hit && (!cpu_write || look_state != ST_S);
  assign granted    = req_q && bus_gnt;
  assign victim_lost = snp_hit_vec[pend_set] && (snp_cmd != CMD_WB);
  assign main_cmd   = pend_write_q ? CMD_RDX : CMD_RD;
  assign fill_state = pend_write_q ? ST_M : (shared_in ? ST_S : ST_E);
  assign cpu_ready  = (fsm_q == F_IDLE);

  always_comb begin
    upd_en    = 1'b0;
    upd_set   = cpu_set;
    upd_tag   = cpu_tag;
    upd_state = ST_M;
    case (fsm_q)
      F_IDLE: begin
        if (cpu_valid && quick_done && cpu_write) upd_en = 1'b1;
      end
      F_WB: begin
        if (granted) begin
          upd_en    = 1'b1;
          upd_set   = pend_set;
          upd_tag   = addr_q[ADDR_W-1:SET_W];
          upd_state = ST_I;
        end
      end
      F_RSP: begin
        upd_en    = 1'b1;
        upd_set   = pend_set;
        upd_tag   = pend_tag;
        upd_state = fill_state;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q        <= F_IDLE;
      pend_addr_q  <= '0;
      pend_write_q <= 1'b0;
      pend_hit_q   <= 1'b0;
      req_q        <= 1'b0;
      cmd_q        <= CMD_NONE;
      addr_q       <= '0;
      rv_q         <= 1'b0;
      rh_q         <= 1'b0;
      rs_q         <= ST_I;
    end else begin
      rv_q <= 1'b0;
      case (fsm_q)
        F_IDLE: begin
          if (cpu_valid) begin
            pend_addr_q  <= cpu_addr;
            pend_write_q <= cpu_write;
            pend_hit_q   <= look_hit;
            if (quick_done) begin
              rv_q <= 1'b1;
              rh_q <= 1'b1;
              rs_q <= cpu_write ? ST_M : look_state;
            end else if (!look_hit && look_state == ST_M) begin
              req_q  <= 1'b1;
              cmd_q  <= CMD_WB;
              addr_q <= {look_tag, cpu_set};
              fsm_q  <= F_WB;
            end else begin
              req_q  <= 1'b1;
              cmd_q  <= cpu_write ? CMD_RDX : CMD_RD;
              addr_q <= cpu_addr;
              fsm_q  <= F_REQ;
            end
          end
        end
        F_WB: begin
          if (victim_lost || granted) begin
            cmd_q  <= main_cmd;
            addr_q <= pend_addr_q;
            fsm_q  <= F_REQ;
          end
        end
        F_REQ: begin
          if (granted) begin
            req_q <= 1'b0;
            cmd_q <= CMD_NONE;
            fsm_q <= F_RSP;
          end
        end
        default: begin
          rv_q  <= 1'b1;
          rh_q  <= pend_hit_q;
          rs_q  <= fill_state;
          fsm_q <= F_IDLE;
        end
      endcase
    end
  end

  assign bus_req    = req_q;
  assign bus_cmd    = cmd_q;
  assign bus_addr   = addr_q;
  assign resp_valid = rv_q;
  assign resp_hit   = rh_q;
  assign resp_state = rs_q;

  // R2: a load hit completes in the next cycle as a hit
  a_r2_load_hit_latency: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && cpu_valid && !cpu_write && look_hit) |=> (resp_valid && resp_hit));

  // R4: an upgrade always asks for ownership
  a_r4_upgrade_rdx: assert property (@(posedge clk) disable iff (rst)
    (fsm_q == F_REQ && pend_hit_q) |-> (bus_cmd == CMD_RDX));

  // R5: a read fill follows the shared input of the response cycle
  a_r5_fill_state: assert property (@(posedge clk) disable iff (rst)
    (fsm_q == F_RSP && !pend_write_q)
      |=> (resp_valid && resp_state == ($past(shared_in) ? ST_S : ST_E)));

  // R11: no bus request while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (fsm_q == F_IDLE) |-> !bus_req);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SET_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [1:0]        resp_state,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              shared_in,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              shared_out,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_addr
);

  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - SET_W;

  logic [TAG_W-1:0] tag_arr   [SETS];
  mesi_t            state_arr [SETS];
  logic [SETS-1:0]  snp_hit_vec;

  bus_cmd_t         snp_cmd;
  logic [SET_W-1:0] snp_set;
  logic [TAG_W-1:0] snp_tag;
  logic [SET_W-1:0] cpu_set;
  mesi_t            cpu_raw;
  mesi_t            cpu_eff;

  logic             upd_en;
  logic [SET_W-1:0] upd_set;
  logic [TAG_W-1:0] upd_tag;
  mesi_t            upd_state;
  bus_cmd_t         cmd_int;
  mesi_t            rs_int;

  assign snp_cmd = bus_cmd_t'(snoop_cmd);
  assign snp_set = snoop_addr[SET_W-1:0];
  assign snp_tag = snoop_addr[ADDR_W-1:SET_W];
  assign cpu_set = cpu_addr[SET_W-1:0];

  for (genvar g = 0; g < SETS; g++) begin : g_slot
    mesi_line_slot #(.TAG_W(TAG_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .snp_sel   (snoop_valid && (snp_set == g)),
      .snp_tag   (snp_tag),
      .snp_cmd   (snp_cmd),
      .upd_en    (upd_en && (upd_set == g)),
      .upd_tag   (upd_tag),
      .upd_state (upd_state),
      .tag_o     (tag_arr[g]),
      .state_o   (state_arr[g]),
      .snp_hit   (snp_hit_vec[g])
    );
  end

  // Processor lookup sees the line after this cycle's snoop has been applied
  assign cpu_raw = state_arr[cpu_set];
  assign cpu_eff = snp_hit_vec[cpu_set] ? snoop_next(cpu_raw, snp_cmd) : cpu_raw;

  mesi_req_fsm #(.ADDR_W(ADDR_W), .SET_W(SET_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cpu_valid   (cpu_valid),
    .cpu_write   (cpu_write),
    .cpu_addr    (cpu_addr),
    .look_state  (cpu_eff),
    .look_tag    (tag_arr[cpu_set]),
    .snp_hit_vec (snp_hit_vec),
    .snp_cmd     (snp_cmd),
    .bus_gnt     (bus_gnt),
    .shared_in   (shared_in),
    .cpu_ready   (cpu_ready),
    .upd_en      (upd_en),
    .upd_set     (upd_set),
    .upd_tag     (upd_tag),
    .upd_state   (upd_state),
    .bus_req     (bus_req),
    .bus_cmd     (cmd_int),
    .bus_addr    (bus_addr),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .resp_state  (rs_int)
  );

  mesi_snoop_resp #(.ADDR_W(ADDR_W)) u_snoop (
    .clk         (clk),
    .rst         (rst),
    .snoop_valid (snoop_valid),
    .snoop_cmd   (snp_cmd),
    .snoop_addr  (snoop_addr),
    .hit         (|snp_hit_vec),
    .hit_state   (state_arr[snp_set]),
    .shared_out  (shared_out),
    .flush_valid (flush_valid),
    .flush_addr  (flush_addr)
  );

  assign bus_cmd    = cmd_int;
  assign resp_state = rs_int;

  // R10: a writeback is only issued for a line this cache holds dirty
  a_r10_wb_is_dirty: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_cmd == CMD_WB)
      |-> (state_arr[bus_addr[SET_W-1:0]] == ST_M));

  // R7: a flush always leaves the set without a dirty copy
  a_r7_flush_clears_dirty: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> (state_arr[flush_addr[SET_W-1:0]] != ST_M
                     || tag_arr[flush_addr[SET_W-1:0]] != flush_addr[ADDR_W-1:SET_W]));

endmodule

// File: tb/test_mesi_snoop_ctrl.sv
module test_mesi_snoop_ctrl;

  localparam int AW = 6;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          cpu_valid [2];
  logic          cpu_write [2];
  logic [AW-1:0] cpu_addr  [2];
  logic          cpu_ready [2];
  logic          resp_valid[2];
  logic          resp_hit  [2];
  logic [1:0]    resp_state[2];
  logic          req       [2];
  logic          gnt       [2];
  logic [1:0]    cmd       [2];
  logic [AW-1:0] baddr     [2];
  logic          shr       [2];
  logic          flv       [2];
  logic [AW-1:0] fla       [2];
  logic          rsp_busy;

  // Fixed-priority arbiter; the cycle after a grant is the response cycle
  assign gnt[0] = req[0] && !rsp_busy;
  assign gnt[1] = req[1] && !rsp_busy && !req[0];
  always @(posedge clk) rsp_busy <= rst ? 1'b0 : (gnt[0] || gnt[1]);

  for (genvar c = 0; c < 2; c++) begin : g_cache
    mesi_snoop_ctrl #(.ADDR_W(AW), .SET_W(2)) i_mesi_snoop_ctrl (
      .clk(clk), .rst(rst),
      .cpu_valid(cpu_valid[c]), .cpu_write(cpu_write[c]), .cpu_addr(cpu_addr[c]),
      .cpu_ready(cpu_ready[c]), .resp_valid(resp_valid[c]), .resp_hit(resp_hit[c]),
      .resp_state(resp_state[c]), .bus_req(req[c]), .bus_gnt(gnt[c]),
      .bus_cmd(cmd[c]), .bus_addr(baddr[c]), .shared_in(shr[1-c]),
      .snoop_valid(gnt[1-c]), .snoop_cmd(cmd[1-c]), .snoop_addr(baddr[1-c]),
      .shared_out(shr[c]), .flush_valid(flv[c]), .flush_addr(fla[c])
    );
  end

  int n_checks = 0;
  int n_fail   = 0;
  int st [2][64];
  int n_rd[2], n_rdx[2], n_wb[2], n_fl[2], n_sh[2];
  logic [AW-1:0] last_fl [2];
  int cycles = 0;

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      for (int c = 0; c < 2; c++) begin
        if (gnt[c] && cmd[c] == 2'd1) n_rd[c]++;
        if (gnt[c] && cmd[c] == 2'd2) n_rdx[c]++;
        if (gnt[c] && cmd[c] == 2'd3) n_wb[c]++;
        if (flv[c]) begin n_fl[c]++; last_fl[c] = fla[c]; end
        if (shr[c]) n_sh[c]++;
      end
    end
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  task automatic wait_resp(input int c, output bit got);
    got = 1'b0;
    for (int k = 0; k < 60 && !got; k++) begin
      if (resp_valid[c]) got = 1'b1;
      else @(negedge clk);
    end
  endtask

  // One operation on cache c against the behavioural model
  task automatic op(input int c, input bit wr, input int a);
    int o, s, os, v, e_rd, e_rdx, e_wb, e_fl, e_sh, x_hit, x_st;
    int b_rd, b_rdx, b_wb, b_fl, b_sh;
    bit got;
    string rq;
    o = 1 - c; s = st[c][a]; os = st[o][a];
    e_rd = 0; e_rdx = 0; e_wb = 0; e_fl = 0; e_sh = 0;
    if (s != 0 && (!wr || s != 1)) begin
      x_hit = 1; x_st = wr ? 3 : s; rq = wr ? "R3" : "R2";
    end else if (s == 1) begin
      x_hit = 1; x_st = 3; rq = "R4"; e_rdx = 1;
      e_fl = (os == 3); st[o][a] = 0;
    end else begin
      x_hit = 0;
      for (int w = 0; w < 64; w++)
        if (w % NS == a % NS && w != a && st[c][w] != 0) begin
          if (st[c][w] == 3) e_wb = 1;
          st[c][w] = 0;
        end
      e_fl = (os == 3);
      if (wr) begin
        rq = "R6"; e_rdx = 1; x_st = 3; st[o][a] = 0;
      end else begin
        rq = "R5"; e_rd = 1; e_sh = (os != 0);
        x_st = (os != 0) ? 1 : 2;
        if (os != 0) st[o][a] = 1;
      end
    end
    st[c][a] = x_st;
    v = 0;
    while (!cpu_ready[c] && v < 60) begin @(negedge clk); v++; end
    b_rd = n_rd[c]; b_rdx = n_rdx[c]; b_wb = n_wb[c]; b_fl = n_fl[o]; b_sh = n_sh[o];
    cpu_valid[c] = 1'b1; cpu_write[c] = wr; cpu_addr[c] = AW'(a);
    @(negedge clk);
    cpu_valid[c] = 1'b0;
    wait_resp(c, got);
    check(got, rq, int'(got), 1);
    check(resp_hit[c] == x_hit[0], rq, int'(resp_hit[c]), x_hit);
    check(int'(resp_state[c]) == x_st, rq, int'(resp_state[c]), x_st);
    @(negedge clk);
    check(n_rd[c] - b_rd == e_rd && n_rdx[c] - b_rdx == e_rdx, rq,
          (n_rd[c] - b_rd) * 10 + (n_rdx[c] - b_rdx), e_rd * 10 + e_rdx);
    check(n_wb[c] - b_wb == e_wb, "R10", n_wb[c] - b_wb, e_wb);
    check(n_fl[o] - b_fl == e_fl, e_rdx ? "R8" : "R7", n_fl[o] - b_fl, e_fl);
    if (e_fl) check(last_fl[o] == AW'(a), "R7", int'(last_fl[o]), a);
    check(n_sh[o] - b_sh == e_sh, "R9", n_sh[o] - b_sh, e_sh);
  endtask

  initial begin
    bit g0, g1;
    int lfsr, c, a;
    for (int i = 0; i < 2; i++) begin
      cpu_valid[i] = 1'b0; cpu_write[i] = 1'b0; cpu_addr[i] = '0;
      n_rd[i] = 0; n_rdx[i] = 0; n_wb[i] = 0; n_fl[i] = 0; n_sh[i] = 0;
      for (int j = 0; j < 64; j++) st[i][j] = 0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      check(cpu_ready[i] && !req[i] && !resp_valid[i] && !shr[i] && !flv[i], "R1",
            {cpu_ready[i], req[i], resp_valid[i], shr[i], flv[i]}, 16);
    end
    op(0, 0, 5);   // R5 miss, no sharer -> E
    op(0, 0, 5);   // R2 hit
    op(0, 1, 5);   // R3 silent E->M
    op(1, 0, 5);   // R7 flush, R9 shared, R12 other holds nothing
    op(1, 1, 5);   // R4 upgrade, R8 silent invalidate
    op(0, 1, 5);   // R6 write miss, R8 flush
    op(0, 0, 9);   // R10 dirty victim written back first
    op(1, 0, 9);   // R7 E->S
    op(0, 0, 13);  // R10 clean victim dropped silently
    op(1, 1, 2);
    op(0, 0, 2);
    // R11: simultaneous upgrades of a line both caches hold Shared
    cpu_valid[0] = 1'b1; cpu_write[0] = 1'b1; cpu_addr[0] = AW'(2);
    cpu_valid[1] = 1'b1; cpu_write[1] = 1'b1; cpu_addr[1] = AW'(2);
    @(negedge clk);
    cpu_valid[0] = 1'b0; cpu_valid[1] = 1'b0;
    g0 = 1'b0; g1 = 1'b0;
    for (int k = 0; k < 60 && !(g0 && g1); k++) begin
      if (resp_valid[0]) begin
        g0 = 1'b1;
        check(resp_hit[0] && resp_state[0] == 2'd3, "R11", int'(resp_state[0]), 3);
      end
      if (resp_valid[1]) begin
        g1 = 1'b1;
        check(resp_hit[1] && resp_state[1] == 2'd3, "R11", int'(resp_state[1]), 3);
      end
      @(negedge clk);
    end
    check(g0 && g1, "R11", int'(g0) + int'(g1), 2);
    st[0][2] = 0; st[1][2] = 3;
    op(0, 0, 2);   // R11 cache 1 must flush its M copy, cache 0 misses
    // R12: pseudo-random traffic; every response is compared with the model
    lfsr = 32'h1d5;
    for (int n = 0; n < 200; n++) begin
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      c = (lfsr >> 8) & 1;
      a = (lfsr >> 10) % 12;
      op(c, ((lfsr >> 20) & 3) == 0, a);
    end
    finish_run();
  end

endmodule